// File: doc/BRIEF.md
# Address-Programmable Clocked Delay Line

This block delays a one-bit signal by a number of clock cycles chosen by a live 4-bit step code. The delay in cycles is a fixed base latency plus the step code times a per-step size. Both the base latency and the step size are parameters. The block drives a true copy of the delayed signal and its complement. An active-low enable forces the true output low and the complement high. While the block is disabled, zeros are shifted into the line, so the input has no effect.

The step code is not captured. The tap follows the code input in the same cycle. Moving the tap deeper would expose history that the output has already shown. A guard prevents this by forcing the output low for exactly as many cycles as the delay grew. When the enable returns before the line has been fully flushed, the guard forces the output low until the zeros from the disabled period reach the tap. A status output reports while the guard is forcing. A second status output reports, during a disable period, that the selected tap now holds only zeros.

Inputs narrower than about a tenth of the total programmed delay should not be relied on in practice. The block itself passes any pulse of one cycle or wider.

Top module: `prog_delay_line`

## Requirements
- R1: After synchronous reset the line holds only zeros, and the guard and flush counters are clear: dout_o=0, dout_n_o=1, hold_o=0, cleared_o=0.
- R2: With the block enabled and the guard idle, dout_o in cycle t equals din_i in cycle t−D, where D = BASE_LAT + STEP × A. A is the unsigned value of addr_i[3:0], so D rises monotonically with the code.
- R3: dout_n_o is always the logical inverse of dout_o.
- R4: While en_n_i is 1, dout_o is 0 and dout_n_o is 1, and a 0 is shifted into the line instead of din_i.
- R5: The tap follows addr_i combinationally, in the same cycle, without latching.
- R6: When addr_i is greater than its value in the previous cycle (0 right after reset), by k codes, dout_o is forced to 0 and hold_o is 1 for k × STEP cycles. The count starts in the cycle of the change. A further increase extends the forced span to whichever end is later.
- R7: A decrease of addr_i does not start a forced span.
- R8: cleared_o is 1 exactly while en_n_i is 1 and the number of consecutive disabled cycles so far is at least D of the current code. The count saturates at the line depth.
- R9: If en_n_i returns to 0 after f disabled cycles with 0 < f < D, dout_o is forced to 0 and hold_o is 1 for D − f cycles, starting in the first enabled cycle.
- R10: din_i values applied while disabled never appear at dout_o after the block is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| din_i | input | 1 | Signal to be delayed |
| addr_i | input | 4 | Live step code selecting the delay |
| en_n_i | input | 1 | Enable, active low; 1 forces outputs and flushes the line |
| dout_o | output | 1 | Delayed signal |
| dout_n_o | output | 1 | Inverse of dout_o |
| hold_o | output | 1 | Guard is forcing the output low |
| cleared_o | output | 1 | Disabled long enough that the selected tap holds only zeros |

## Verification
A wrong bit in the shift line shows up on dout_o exactly D cycles after it was written, and only if the guard is not forcing the output at that moment. A short run at one code can therefore hide it, so the data is swept over several codes. A wrong guard count shows at once as a missing or extra forced cycle on hold_o, and then as a stale pulse or a dropped pulse on dout_o. A wrong flush count shows on cleared_o in the cycle it should change, and on re-enable as too short or too long a forced span. The reference model is compared on every cycle, so each of these faults is reported in the first cycle it reaches a port.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
    localparam int ADDR_W   = 4;
    localparam int NUM_TAPS = 1 << ADDR_W;

    // delay in cycles selected by one step code
    function automatic int tap_cycles(input int base, input int step, input int code);
        return base + step * code;
    endfunction
endpackage

// File: rtl/pdl_chain.sv
module pdl_chain
    import pdl_pkg::*;
#(
    parameter int BASE_LAT = 3,
    parameter int STEP     = 2,
    parameter int DEPTH    = BASE_LAT + (NUM_TAPS - 1) * STEP
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              din_i,
    input  logic              en_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              tap_o
);
    typedef struct packed {
        logic [DEPTH-1:0] line;
    } chain_t;

    chain_t st_d, st_q;
    logic   entry;
    logic [NUM_TAPS-1:0] taps;

    // disabled line takes zeros so it flushes itself
    assign entry = en_n_i ? 1'b0 : din_i;

    always_comb begin
        st_d      = st_q;
        st_d.line = {st_q.line[DEPTH-2:0], entry};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // one fixed tap per code, selected live by the code
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign taps[g] = st_q.line[tap_cycles(BASE_LAT, STEP, g) - 1];
    end

    assign tap_o = taps[addr_i];

    // R4: nothing but zero enters while disabled
    a_r4_zero_in: assert property (@(posedge clk_i) disable iff (rst_i)
        en_n_i |=> !st_q.line[0]);
endmodule

// File: rtl/pdl_guard.sv
module pdl_guard
    import pdl_pkg::*;
#(
    parameter int BASE_LAT = 3,
    parameter int STEP     = 2,
    parameter int DEPTH    = BASE_LAT + (NUM_TAPS - 1) * STEP
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en_n_i,
    output logic              blank_o,
    output logic              cleared_o
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CW-1:0]     hold;
        logic [CW-1:0]     flush;
    } guard_t;

    guard_t st_d, st_q;

    logic [CW-1:0] span;
    logic [CW-1:0] inc_req;
    logic [CW-1:0] ren_req;
    logic [CW-1:0] req;
    logic [CW-1:0] rem;

    always_comb begin
        span = CW'(tap_cycles(BASE_LAT, STEP, int'(addr_i)));

        // deeper tap: blank while the tap shows already-emitted history
        if (addr_i > st_q.addr) begin
            inc_req = CW'(STEP * (int'(addr_i) - int'(st_q.addr)));
        end else begin
            inc_req = '0;
        end

        // early re-enable: blank until the flushed zeros reach the tap
        if (!en_n_i && st_q.flush != '0 && st_q.flush < span) begin
            ren_req = span - st_q.flush;
        end else begin
            ren_req = '0;
        end

        req = (inc_req > ren_req) ? inc_req : ren_req;
        rem = (st_q.hold != '0) ? st_q.hold - 1'b1 : '0;

        st_d      = st_q;
        st_d.addr = addr_i;
        if (req != '0 && (req - 1'b1) > rem) begin
            st_d.hold = req - 1'b1;
        end else begin
            st_d.hold = rem;
        end

        if (!en_n_i) begin
            st_d.flush = '0;
        end else if (st_q.flush == CW'(DEPTH)) begin
            st_d.flush = st_q.flush;
        end else begin
            st_d.flush = st_q.flush + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign blank_o   = (req != '0) || (st_q.hold != '0);
    assign cleared_o = en_n_i && (st_q.flush >= span);

    // R6: any upward code step blanks in the cycle it happens
    a_r6_inc_blanks: assert property (@(posedge clk_i) disable iff (rst_i)
        (addr_i > $past(addr_i)) |-> blank_o);

    // R7: a downward step with an idle guard starts no blanking
    a_r7_dec_no_blank: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(en_n_i) && !en_n_i && addr_i < $past(addr_i)
         && st_q.hold == '0) |-> !blank_o);

    // R8: once cleared, staying disabled at the same code keeps it cleared
    a_r8_cleared_stays: assert property (@(posedge clk_i) disable iff (rst_i)
        (cleared_o && en_n_i) ##1 (en_n_i && $stable(addr_i)) |-> cleared_o);

    // R8: flush count never passes the line depth
    always_ff @(posedge clk_i) begin
        if (!rst_i) begin
            a_r8_flush_sat: assert (st_q.flush <= CW'(DEPTH));
        end
    end
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line
    import pdl_pkg::*;
#(
    parameter int BASE_LAT = 3,
    parameter int STEP     = 2
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       din_i,
    input  logic [3:0] addr_i,
    input  logic       en_n_i,
    output logic       dout_o,
    output logic       dout_n_o,
    output logic       hold_o,
    output logic       cleared_o
);
    localparam int DEPTH = BASE_LAT + (NUM_TAPS - 1) * STEP;

    logic tap;
    logic blank;

    pdl_chain #(.BASE_LAT(BASE_LAT), .STEP(STEP), .DEPTH(DEPTH)) u_chain (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .din_i  (din_i),
        .en_n_i (en_n_i),
        .addr_i (addr_i),
        .tap_o  (tap)
    );

    pdl_guard #(.BASE_LAT(BASE_LAT), .STEP(STEP), .DEPTH(DEPTH)) u_guard (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .addr_i    (addr_i),
        .en_n_i    (en_n_i),
        .blank_o   (blank),
        .cleared_o (cleared_o)
    );

    assign dout_o   = !en_n_i && !blank && tap;
    assign dout_n_o = !dout_o;
    assign hold_o   = blank;

    // R4: a disable seen at an edge leaves the true output low one cycle on if still disabled
    a_r4_forced_levels: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_n_i ##1 en_n_i) |-> (!dout_o && dout_n_o));
endmodule

// File: tb/prog_delay_line_tb.sv
`timescale 1ns/1ps
module prog_delay_line_tb;
    localparam int BASE_LAT = 3;
    localparam int STEP     = 2;
    localparam int DEPTH    = BASE_LAT + 15 * STEP;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [3:0] addr = 4'd0;
    logic       en_n = 1'b0;
    logic       dout, dout_n, hold, cleared;

    always #2.5 clk = ~clk;

    prog_delay_line #(.BASE_LAT(BASE_LAT), .STEP(STEP)) u_dut (
        .clk_i(clk), .rst_i(rst), .din_i(din), .addr_i(addr), .en_n_i(en_n),
        .dout_o(dout), .dout_n_o(dout_n), .hold_o(hold), .cleared_o(cleared)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    // reference state: what entered the line, time, guard end, disabled run
    bit hist[$];
    int t = 0, hold_end = 0, dis_run = 0, prev_addr = 0;

    task automatic check(input string rq, input string sig, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s at t=%0d: actual %b expected %b", rq, sig, t, got, exp);
        end
    endtask

    task automatic step(input logic d, input int a, input logic e);
        int  dly, need;
        bit  blank, tapv, expo;
        @(negedge clk);
        din = d; addr = a[3:0]; en_n = e;
        #1;
        dly  = BASE_LAT + STEP * a;
        need = 0;
        if (a > prev_addr) need = (a - prev_addr) * STEP;
        if (!e && dis_run > 0 && dis_run < dly && (dly - dis_run) > need) need = dly - dis_run;
        if (t + need > hold_end) hold_end = t + need;
        blank = (t < hold_end);
        tapv  = (hist.size() >= dly) ? hist[hist.size() - dly] : 1'b0;
        expo  = !e && !blank && tapv;
        check(tag, "dout", dout, expo);
        check("R3", "dout_n", dout_n, !expo);
        check(tag, "hold", hold, blank);
        check("R8", "cleared", cleared, e && (dis_run >= dly));
        hist.push_back(e ? 1'b0 : d);
        if (hist.size() > DEPTH + 4) void'(hist.pop_front());
        dis_run   = e ? ((dis_run < DEPTH) ? dis_run + 1 : DEPTH) : 0;
        prev_addr = a;
        t++;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state at the ports
        check("R1", "dout", dout, 1'b0);
        check("R1", "dout_n", dout_n, 1'b1);
        check("R1", "hold", hold, 1'b0);
        check("R1", "cleared", cleared, 1'b0);
        tag = "R1";
        for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b0);

        // R2: single pulse at code 0, then varied widths at code 3
        tag = "R2";
        step(1'b1, 0, 1'b0);
        for (int i = 0; i < 8; i++) step(1'b0, 0, 1'b0);
        tag = "R6";
        for (int i = 0; i < 8; i++) step(1'b0, 3, 1'b0);
        tag = "R2";
        for (int i = 0; i < 30; i++) step(((i % 7) < (i % 4)) ? 1'b1 : 1'b0, 3, 1'b0);

        // R6: stream high, raise to 15, blanked span hides old history
        tag = "R6";
        for (int i = 0; i < 12; i++) step(1'b1, 3, 1'b0);
        for (int i = 0; i < 40; i++) step(i[1], 15, 1'b0);
        // R6: back-to-back increases extend the span
        for (int i = 0; i < 3; i++) step(1'b1, 2, 1'b0);
        step(1'b1, 4, 1'b0);
        step(1'b0, 5, 1'b0);
        step(1'b1, 9, 1'b0);
        for (int i = 0; i < 30; i++) step(i[0], 9, 1'b0);

        // R7: decrease mid-stream, no blanking
        tag = "R7";
        for (int i = 0; i < 20; i++) step(i[2], 6, 1'b0);
        for (int i = 0; i < 20; i++) step(i[1], 2, 1'b0);

        // R5: code moves every cycle downward with data streaming
        tag = "R5";
        for (int i = 15; i >= 0; i--) step(i[0], i, 1'b0);
        for (int i = 0; i < 20; i++) step(i[1] ^ i[0], 0, 1'b0);

        // R4 and R9: short disable at code 5 (D=13), input toggling
        tag = "R4";
        for (int i = 0; i < 15; i++) step(1'b1, 5, 1'b0);
        for (int i = 0; i < 5; i++) step(i[0], 5, 1'b1);
        tag = "R9";
        for (int i = 0; i < 20; i++) step(1'b0, 5, 1'b0);

        // R8 and R10: long disable with input high, then quiet re-enable
        tag = "R8";
        for (int i = 0; i < 10; i++) step(1'b1, 7, 1'b0);
        for (int i = 0; i < 40; i++) step(1'b1, 7, 1'b1);
        step(1'b1, 12, 1'b1);
        for (int i = 0; i < 10; i++) step(1'b1, 12, 1'b1);
        tag = "R10";
        for (int i = 0; i < 35; i++) step(1'b0, 12, 1'b0);

        // R2: mixed stress
        tag = "R2";
        begin
            int a = 4;
            bit e = 1'b0;
            for (int i = 0; i < 1500; i++) begin
                if ($urandom_range(0, 19) == 0) a = $urandom_range(0, 15);
                if ($urandom_range(0, 29) == 0) e = ~e;
                step($urandom_range(0, 1) == 1, a, e);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule